// File: doc/BRIEF.md
# Three-Engine SAR Converter Control Registers

This block is the register front end for one successive-approximation converter shared by three measurement engines: a touch engine that takes a pair of samples, a battery engine and an auxiliary-input engine. Software works through a 32-bit register port with per-byte write strobes. It arms an engine by setting its bit in the engine-enable register. The block runs that engine's conversion through a request/done handshake with the converter. When the conversion ends, the block stores the 12-bit result, clears the engine bit, sets the engine's pending flag and drives one combined interrupt line.

The block also produces a clock enable for the converter. It divides the system clock by a programmable ratio taken from the configuration register. It takes pen-down and pen-up event pulses from the touch front end and turns them into pending flags. Software can abort a conversion that hangs by clearing the engine bit. Any result that arrives after the abort is dropped.

Top module: `adc_ctl`

## Requirements
- R1: After reset the engine-enable register reads 0, the mask register reads 0x1F (all masked), the pending register reads 0, the configuration register reads 0, and both `irq` and `cnv_req` are low.
- R2: A register write changes only the bytes whose `bus_be` strobe is set. The same-point and wait registers are 16 bits wide at word offsets 0x10 and 0x14.
- R3: Configuration bits that are not implemented read as zero, so the writable mask is 0xC007FDF0. The divider field is bits 8:5. `rng_2v5` follows configuration bit 4 (1 selects the 2.5 V range).
- R4: When several engines are armed (enable word 0x00: touch bit 2, battery bit 1, auxiliary bit 0), they are served strictly as touch, then battery, then auxiliary. `cnv_sel` carries 2 for touch, 1 for battery and 0 for auxiliary.
- R5: When an engine's conversion ends, its enable bit clears by itself. Its result reads right-aligned in bits 11:0 of its data register: battery at 0x1C, auxiliary at 0x20.
- R6: The touch engine performs two conversions. The first result goes to bits 11:0 of offset 0x18, with its `cnv_flag` in bit 15. The second goes to bits 27:16, with its flag in bit 31. The touch pending flag is set only after the second conversion.
- R7: Writing to the pending register (0x0C) clears each bit written as 1 and leaves bits written as 0 untouched. An event that sets a bit in the same cycle as a clear of that bit wins.
- R8: A pending flag is set even when its interrupt is masked. `irq` is high exactly when some pending bit has a 0 in the mask register (0x08).
- R9: Clearing the enable bit of the engine in service drops `cnv_req` in the next cycle. A `cnv_done` that arrives afterwards sets no pending flag and leaves the result register unchanged.
- R10: `cnv_tick` pulses once every (divider + 1) system clock cycles.
- R11: A `pen_down` pulse sets pending bit 4 and a `pen_up` pulse sets pending bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte address, word aligned |
| bus_be | input | 4 | Byte write strobes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| pen_down | input | 1 | Pen-down event pulse |
| pen_up | input | 1 | Pen-up event pulse |
| cnv_req | output | 1 | Conversion request, held until done or abort |
| cnv_sel | output | 2 | Engine in service (2 touch, 1 battery, 0 auxiliary) |
| cnv_tick | output | 1 | Converter clock enable |
| rng_2v5 | output | 1 | Battery range select to the analog side |
| cnv_done | input | 1 | One-cycle conversion complete |
| cnv_data | input | 12 | Conversion result |
| cnv_flag | input | 1 | Sample type flag returned with a touch result |
| irq | output | 1 | Combined interrupt |

## Verification
The hardest case to reach is a converter that keeps converting after software has aborted and then reports a result into an idle sequencer. The bench's converter model has a mode in which it ignores the falling request and finishes its count of ticks anyway. The bench arms the battery engine with a slow divider, clears the bit partway through, and then checks that the late result changed neither the pending flags nor the battery result. Arbitration order is checked for all seven combinations of armed engines against a log kept by the converter model.

// File: rtl/adc_ctl_pkg.sv
package adc_ctl_pkg;

    localparam int DATA_W  = 12;
    localparam int NUM_ENG = 3;
    localparam int NUM_IRQ = 5;
    localparam int DIV_LSB = 5;
    localparam int DIV_W   = 4;
    localparam int RNG_BIT = 4;

    localparam logic [31:0] CFG_WMASK = 32'hC007_FDF0;

    // word indices of the register map
    localparam logic [3:0] W_EN   = 4'd0;
    localparam logic [3:0] W_CFG  = 4'd1;
    localparam logic [3:0] W_MSK  = 4'd2;
    localparam logic [3:0] W_STS  = 4'd3;
    localparam logic [3:0] W_SAME = 4'd4;
    localparam logic [3:0] W_WAIT = 4'd5;
    localparam logic [3:0] W_TCH  = 4'd6;
    localparam logic [3:0] W_BAT  = 4'd7;
    localparam logic [3:0] W_AUX  = 4'd8;

    typedef enum logic [1:0] {
        ENG_AUX = 2'd0,
        ENG_BAT = 2'd1,
        ENG_TCH = 2'd2
    } eng_e;

    typedef enum logic {
        SQ_IDLE = 1'b0,
        SQ_CONV = 1'b1
    } seq_e;

    typedef struct packed {
        logic              flag;
        logic [DATA_W-1:0] val;
    } sample_t;

    function automatic eng_e pick_eng(input logic [NUM_ENG-1:0] en);
        if (en[ENG_TCH])      return ENG_TCH;
        else if (en[ENG_BAT]) return ENG_BAT;
        else                  return ENG_AUX;
    endfunction

    function automatic logic [31:0] lane_merge(input logic [31:0] old,
                                               input logic [31:0] nw,
                                               input logic [3:0]  be);
        logic [31:0] r;
        for (int i = 0; i < 4; i++)
            r[i*8 +: 8] = be[i] ? nw[i*8 +: 8] : old[i*8 +: 8];
        return r;
    endfunction

    function automatic logic [31:0] pack_touch(input sample_t s0, input sample_t s1);
        logic [31:0] r;
        r = '0;
        r[DATA_W-1:0]      = s0.val;
        r[15]              = s0.flag;
        r[16 +: DATA_W]    = s1.val;
        r[31]              = s1.flag;
        return r;
    endfunction

endpackage

// File: rtl/adc_ctl_clkdiv.sv
module adc_ctl_clkdiv
    import adc_ctl_pkg::*;
#(
    parameter int W = DIV_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] div,
    output logic         tick
);
    logic [W-1:0] cnt_q;

    assign tick = (cnt_q >= div);

    always_ff @(posedge clk) begin
        if (rst)       cnt_q <= '0;
        else if (tick) cnt_q <= '0;
        else           cnt_q <= cnt_q + 1'b1;
    end

    // R10: with a nonzero, unchanged ratio two ticks never touch
    p_tick_gap_r10: assert property (@(posedge clk) disable iff (rst)
        (tick && div != '0 && $stable(div)) |=> !tick);
endmodule

// File: rtl/adc_ctl_seq.sv
module adc_ctl_seq
    import adc_ctl_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_ENG-1:0] en,
    input  logic               cnv_done,
    output logic               cnv_req,
    output eng_e               cur_eng,
    output logic               acc,
    output logic               acc_second,
    output logic               fin
);
    seq_e st_q;
    eng_e cur_q;
    logic half_q;

    assign cur_eng    = cur_q;
    assign cnv_req    = (st_q == SQ_CONV) && en[cur_q];
    assign acc        = cnv_req && cnv_done;
    assign acc_second = half_q;
    assign fin        = acc && !((cur_q == ENG_TCH) && !half_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= SQ_IDLE;
            cur_q  <= ENG_AUX;
            half_q <= 1'b0;
        end else begin
            case (st_q)
                SQ_IDLE: begin
                    if (|en) begin
                        cur_q  <= pick_eng(en);
                        half_q <= 1'b0;
                        st_q   <= SQ_CONV;
                    end
                end
                default: begin
                    if (!en[cur_q])  st_q <= SQ_IDLE;
                    else if (fin)    st_q <= SQ_IDLE;
                    else if (acc)    half_q <= 1'b1;
                end
            endcase
        end
    end

    // R4: an armed touch engine always wins the next selection
    p_touch_first_r4: assert property (@(posedge clk) disable iff (rst)
        (st_q == SQ_IDLE && en[ENG_TCH]) |=> (cur_q == ENG_TCH));
endmodule

// File: rtl/adc_ctl.sv
module adc_ctl
    import adc_ctl_pkg::*;
#(
    parameter int SAME_W = 16,
    parameter int WAIT_W = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic [5:0]  bus_addr,
    input  logic [3:0]  bus_be,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        pen_down,
    input  logic        pen_up,
    output logic        cnv_req,
    output logic [1:0]  cnv_sel,
    output logic        cnv_tick,
    output logic        rng_2v5,
    input  logic        cnv_done,
    input  logic [11:0] cnv_data,
    input  logic        cnv_flag,
    output logic        irq
);
    logic [NUM_ENG-1:0] en_q;
    logic [31:0]        cfg_q;
    logic [NUM_IRQ-1:0] msk_q, sts_q;
    logic [SAME_W-1:0]  same_q;
    logic [WAIT_W-1:0]  wait_q;
    sample_t            tch0_q, tch1_q;
    logic [DATA_W-1:0]  bat_q, aux_q;

    eng_e               cur;
    logic               acc, acc_second, fin;
    logic [NUM_ENG-1:0] fin_vec;
    logic [NUM_IRQ-1:0] set_vec, clr_vec;
    logic [3:0]         widx;
    logic               wr_any, wr_en, wr_cfg, wr_msk, wr_sts, wr_same, wr_wait;
    logic [31:0]        cfg_m;

    assign widx    = bus_addr[5:2];
    assign wr_any  = bus_sel && bus_wr;
    assign wr_en   = wr_any && widx == W_EN   && bus_be[0];
    assign wr_cfg  = wr_any && widx == W_CFG;
    assign wr_msk  = wr_any && widx == W_MSK  && bus_be[0];
    assign wr_sts  = wr_any && widx == W_STS  && bus_be[0];
    assign wr_same = wr_any && widx == W_SAME;
    assign wr_wait = wr_any && widx == W_WAIT;

    adc_ctl_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .en         (en_q),
        .cnv_done   (cnv_done),
        .cnv_req    (cnv_req),
        .cur_eng    (cur),
        .acc        (acc),
        .acc_second (acc_second),
        .fin        (fin)
    );

    adc_ctl_clkdiv #(.W(DIV_W)) u_div (
        .clk  (clk),
        .rst  (rst),
        .div  (cfg_q[DIV_LSB +: DIV_W]),
        .tick (cnv_tick)
    );

    assign cnv_sel = cur;
    assign rng_2v5 = cfg_q[RNG_BIT];

    always_comb begin
        fin_vec = '0;
        if (fin) fin_vec[cur] = 1'b1;
        set_vec = {pen_down, pen_up, fin_vec};
        clr_vec = wr_sts ? bus_wdata[NUM_IRQ-1:0] : '0;
        cfg_m   = lane_merge(cfg_q, bus_wdata, bus_be) & CFG_WMASK;
    end

    // engine enables: a register write overrides hardware self-clear
    always_ff @(posedge clk) begin
        if (rst)        en_q <= '0;
        else if (wr_en) en_q <= bus_wdata[NUM_ENG-1:0];
        else            en_q <= en_q & ~fin_vec;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= '0;
            msk_q  <= '1;
            sts_q  <= '0;
            same_q <= '0;
            wait_q <= '0;
        end else begin
            if (wr_cfg) cfg_q <= cfg_m;
            if (wr_msk) msk_q <= bus_wdata[NUM_IRQ-1:0];
            sts_q <= (sts_q & ~clr_vec) | set_vec;
            if (wr_same)
                same_q <= SAME_W'(lane_merge(32'(same_q), bus_wdata, bus_be));
            if (wr_wait)
                wait_q <= WAIT_W'(lane_merge(32'(wait_q), bus_wdata, bus_be));
        end
    end

    // result capture
    always_ff @(posedge clk) begin
        if (rst) begin
            tch0_q <= '0;
            tch1_q <= '0;
            bat_q  <= '0;
            aux_q  <= '0;
        end else if (acc) begin
            case (cur)
                ENG_TCH: begin
                    if (acc_second) tch1_q <= '{flag: cnv_flag, val: cnv_data};
                    else            tch0_q <= '{flag: cnv_flag, val: cnv_data};
                end
                ENG_BAT: bat_q <= cnv_data;
                default: aux_q <= cnv_data;
            endcase
        end
    end

    assign irq = |(sts_q & ~msk_q);

    always_comb begin
        case (widx)
            W_EN:    bus_rdata = 32'(en_q);
            W_CFG:   bus_rdata = cfg_q;
            W_MSK:   bus_rdata = 32'(msk_q);
            W_STS:   bus_rdata = 32'(sts_q);
            W_SAME:  bus_rdata = 32'(same_q);
            W_WAIT:  bus_rdata = 32'(wait_q);
            W_TCH:   bus_rdata = pack_touch(tch0_q, tch1_q);
            W_BAT:   bus_rdata = 32'(bat_q);
            W_AUX:   bus_rdata = 32'(aux_q);
            default: bus_rdata = '0;
        endcase
    end

    // R5: a finished engine is disarmed unless software rewrote the enables
    p_selfclear_r5: assert property (@(posedge clk) disable iff (rst)
        (fin && !wr_en) |=> ((en_q & $past(fin_vec)) == '0));

    // R8: completion raises its pending flag regardless of the mask
    p_pending_r8: assert property (@(posedge clk) disable iff (rst)
        fin |=> ((sts_q & NUM_IRQ'($past(fin_vec))) == NUM_IRQ'($past(fin_vec))));

    // R9: clearing the engine in service withdraws the request
    p_abort_r9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && cnv_req && !bus_wdata[cnv_sel]) |=> !cnv_req);
endmodule

// File: tb/test_adc_ctl.sv
`timescale 1ns/1ps
module test_adc_ctl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        pen_down = 1'b0, pen_up = 1'b0;
    logic        cnv_req, cnv_tick, rng_2v5, irq;
    logic [1:0]  cnv_sel;
    logic        cnv_done;
    logic [11:0] cnv_data;
    logic        cnv_flag;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    adc_ctl i_adc_ctl (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .pen_down(pen_down), .pen_up(pen_up),
        .cnv_req(cnv_req), .cnv_sel(cnv_sel), .cnv_tick(cnv_tick),
        .rng_2v5(rng_2v5), .cnv_done(cnv_done), .cnv_data(cnv_data),
        .cnv_flag(cnv_flag), .irq(irq)
    );

    // converter model: 12 ticks per conversion, logs every result it returns
    logic        stubborn = 1'b0;
    logic        m_busy;
    int          m_cnt;
    logic [1:0]  m_sel;
    int          serial;
    logic [1:0]  log_eng [64];
    int          log_n;
    logic [11:0] last_val [3];
    logic [11:0] t_val [2];
    logic        t_flag [2];
    logic        t_half;

    always @(posedge clk) begin
        if (rst) begin
            m_busy <= 1'b0; m_cnt <= 0; m_sel <= 2'd0; serial <= 1;
            cnv_done <= 1'b0; cnv_data <= '0; cnv_flag <= 1'b0;
            log_n <= 0; t_half <= 1'b0;
        end else begin
            cnv_done <= 1'b0;
            if (m_busy) begin
                if (!cnv_req && !stubborn) m_busy <= 1'b0;
                else if (cnv_tick) begin
                    if (m_cnt == 11) begin
                        logic [11:0] v;
                        v = 12'((serial * 37 + int'(m_sel) * 5) & 32'hFFF);
                        m_busy   <= 1'b0;
                        cnv_done <= 1'b1;
                        cnv_data <= v;
                        cnv_flag <= serial[0];
                        serial   <= serial + 1;
                        log_eng[log_n % 64] <= m_sel;
                        log_n    <= log_n + 1;
                        last_val[m_sel] <= v;
                        if (m_sel == 2'd2) begin
                            t_val[t_half]  <= v;
                            t_flag[t_half] <= serial[0];
                            t_half <= ~t_half;
                        end
                    end else m_cnt <= m_cnt + 1;
                end
            end else if (cnv_req && !cnv_done) begin
                m_busy <= 1'b1; m_cnt <= 0; m_sel <= cnv_sel;
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_be = '0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        for (int i = 0; i < 4000; i++) begin
            rd(6'h00, v);
            if (v == 0) break;
        end
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] v, base_bat;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(6'h00, v); chk("R1 enable", v, 0);
        rd(6'h08, v); chk("R1 mask", v, 32'h1F);
        rd(6'h0C, v); chk("R1 pending", v, 0);
        rd(6'h04, v); chk("R1 config", v, 0);
        chk("R1 irq", 32'(irq), 0);
        chk("R1 cnv_req", 32'(cnv_req), 0);

        // R2/R3 byte lanes and implemented config bits
        wr(6'h04, 32'hFFFF_FFFF, 4'b0001);
        rd(6'h04, v); chk("R2 cfg lane0", v, 32'h0000_00F0);
        chk("R3 rng_2v5 high", 32'(rng_2v5), 1);
        wr(6'h04, 32'hFFFF_FFFF, 4'b1100);
        rd(6'h04, v); chk("R3 cfg upper lanes", v, 32'hC007_00F0);
        wr(6'h04, 32'hFFFF_FFFF, 4'b1111);
        rd(6'h04, v); chk("R3 cfg all", v, 32'hC007_FDF0);
        wr(6'h04, 32'h0, 4'b1111);
        chk("R3 rng_2v5 low", 32'(rng_2v5), 0);
        wr(6'h10, 32'hABCD_1234, 4'b0011);
        rd(6'h10, v); chk("R2 same low lanes", v, 32'h1234);
        wr(6'h10, 32'hFFFF_FFFF, 4'b0100);
        rd(6'h10, v); chk("R2 same lane2 no effect", v, 32'h1234);
        wr(6'h14, 32'h0000_5A00, 4'b0010);
        rd(6'h14, v); chk("R2 wait lane1", v, 32'h5A00);

        // R4/R5/R6 sweep every combination of armed engines
        for (int e = 1; e < 8; e++) begin
            int base, n;
            int exp_ord [4];
            n = 0;
            if (e[2]) begin exp_ord[n] = 2; exp_ord[n+1] = 2; n += 2; end
            if (e[1]) begin exp_ord[n] = 1; n++; end
            if (e[0]) begin exp_ord[n] = 0; n++; end
            wr(6'h0C, 32'h1F, 4'b0001);
            base = log_n;
            wr(6'h00, 32'(e), 4'b0001);
            wait_idle();
            chk("R4 conversion count", 32'(log_n - base), 32'(n));
            for (int k = 0; k < n; k++)
                chk("R4 service order", 32'(log_eng[(base + k) % 64]), 32'(exp_ord[k]));
            rd(6'h00, v); chk("R5 enable self-clear", v, 0);
            rd(6'h0C, v); chk("R5 pending flags", v, 32'(e));
            if (e[1]) begin rd(6'h1C, v); chk("R5 battery result", v, 32'(last_val[1])); end
            if (e[0]) begin rd(6'h20, v); chk("R5 aux result", v, 32'(last_val[0])); end
            if (e[2]) begin
                rd(6'h18, v);
                chk("R6 touch pair", v, {t_flag[1], 3'b0, t_val[1], t_flag[0], 3'b0, t_val[0]});
            end
        end

        // R11 pen events; R8 irq across every mask value
        @(negedge clk); pen_down = 1'b1; pen_up = 1'b1;
        @(negedge clk); pen_down = 1'b0; pen_up = 1'b0;
        rd(6'h0C, v); chk("R11 pen bits", v, 32'h1F);
        for (int m = 0; m < 32; m++) begin
            wr(6'h08, 32'(m), 4'b0001);
            chk("R8 irq vs mask", 32'(irq), 32'(m != 31));
        end

        // R7 write-one-to-clear
        wr(6'h0C, 32'h00, 4'b0001);
        rd(6'h0C, v); chk("R7 zero write no effect", v, 32'h1F);
        wr(6'h0C, 32'h05, 4'b0001);
        rd(6'h0C, v); chk("R7 partial clear", v, 32'h1A);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 6'h0C; bus_wdata = 32'h10; bus_be = 4'b0001;
        pen_down = 1'b1;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_be = '0; pen_down = 1'b0;
        rd(6'h0C, v); chk("R7 set wins over clear", v, 32'h1A);

        // R8 pending set while masked, irq stays low
        wr(6'h0C, 32'hFF, 4'b0001);
        wr(6'h00, 32'h1, 4'b0001);
        wait_idle();
        rd(6'h0C, v); chk("R8 masked pending set", v, 32'h01);
        chk("R8 masked irq low", 32'(irq), 0);
        wr(6'h08, 32'h1E, 4'b0001);
        chk("R8 unmasked irq high", 32'(irq), 1);
        wr(6'h0C, 32'h01, 4'b0001);
        chk("R8 irq drops after clear", 32'(irq), 0);

        // R10 tick period for every divider value
        for (int d = 0; d < 16; d++) begin
            int gap;
            wr(6'h04, 32'(d) << 5, 4'b0011);
            for (int s = 0; s < 2; s++) begin
                @(negedge clk);
                while (!cnv_tick) @(negedge clk);
            end
            gap = 0;
            do begin @(negedge clk); gap++; end while (!cnv_tick);
            chk("R10 tick period", 32'(gap), 32'(d + 1));
        end

        // R9 abort with a late result from the converter
        wr(6'h04, 32'd3 << 5, 4'b0011);
        wr(6'h0C, 32'h1F, 4'b0001);
        rd(6'h1C, base_bat);
        stubborn = 1'b1;
        wr(6'h00, 32'h2, 4'b0001);
        repeat (10) @(negedge clk);
        chk("R9 request active", 32'(cnv_req), 1);
        wr(6'h00, 32'h0, 4'b0001);
        chk("R9 request withdrawn", 32'(cnv_req), 0);
        repeat (100) @(negedge clk);
        rd(6'h0C, v); chk("R9 no pending after abort", v, 0);
        rd(6'h1C, v); chk("R9 battery result kept", v, base_bat);
        rd(6'h00, v); chk("R9 enable stays clear", v, 0);
        stubborn = 1'b0;

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule